// File: doc/BRIEF.md
# Dual-Port Sample ROM Sharing Bridge

Two sound-sample fetch ports share a single external sample ROM through this bridge. Each port talks over an 8-bit bus that carries address and data at different times. A strobe marks each address phase, and an output-enable marks the read. Each port also has a few dedicated address lines. The bridge latches two address bytes per port and combines them with the dedicated lines to form a 22-bit address. It then drives the ROM address bus from a slot sequencer that runs on the system clock. At the end of the slot it captures the ROM byte into that port's data latch. The port's bus returns the latched byte while its output-enable is high.

A free-running slot counter divides time into slots of `SLOT_LEN` clocks, and each slot serves at most one request. When both ports are waiting, the slots alternate between them. A mode input selects how the top four ROM address lines are used. They either carry address bits, or they act as four active-low bank selects decoded from two internal address bits. A separate inverter path is also included.

The strobe and output-enable inputs are sampled on `clk`, and the bridge acts on their rising edges. The interface is plain and has no handshake. The ROM must return valid data within `SLOT_LEN-1` clocks of an address change. Each port must wait at least `3*SLOT_LEN` clocks after its second strobe before it raises its output-enable. The bridge applies no back-pressure.

Top module: `sample_rom_bridge`

## Requirements
- R1: After a synchronous reset, both bus-enable outputs and both bus outputs are 0. With `linear_mode` low, `rom_addr[23:20]` reads 4'hF.
- R2: Port A forms its 22-bit address from four sources, in increasing bit order. Bits 7:0 are the first strobe byte and bits 9:8 are `a_side[1:0]`. Bits 17:10 are the second strobe byte and bits 21:18 are `a_side[5:2]`. The returned byte is the ROM data at that address.
- R3: Port B forms its address from three sources, in increasing bit order. Bits 7:0 are the first strobe byte, bits 11:8 are `b_side[3:0]` and bits 19:12 are the second strobe byte. Bits 21:20 are 0. The returned byte is the ROM data at that address.
- R4: A rising edge of a port's output-enable returns that port's byte tracker to the low-byte phase. The next strobe after it loads the low address byte.
- R5: While a port's output-enable is high, its bus output equals its latched ROM byte and its bus-enable is 1. Otherwise the bus-enable is 0 and the bus output is 0.
- R6: Requests from both ports issued together are both completed within `3*SLOT_LEN` clocks of the second strobe. When both are pending, the slots alternate between the ports.
- R7: With `linear_mode` high, `rom_addr[21:0]` carries the 22-bit address and `rom_addr[23:22]` is 0. With `linear_mode` low and an access in progress, `rom_addr[19:0]` carries address bits 19:0. In that case `rom_addr[23:20]` is active-low one-hot, and line 20+k is low when address bits 21:20 equal k.
- R8: With `linear_mode` low and no access in progress, all four select lines `rom_addr[23:20]` are high.
- R9: `inv_out` is always the inverse of `inv_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| linear_mode | input | 1 | 1: top ROM lines carry address bits; 0: bank-select decode |
| a_bus_in | input | 8 | Port A multiplexed bus, input side |
| a_strobe | input | 1 | Port A address-phase strobe |
| a_oe | input | 1 | Port A read enable |
| a_side | input | 6 | Port A dedicated address lines |
| a_bus_out | output | 8 | Port A multiplexed bus, output side |
| a_bus_oe | output | 1 | Port A bus drive enable |
| b_bus_in | input | 8 | Port B multiplexed bus, input side |
| b_strobe | input | 1 | Port B address-phase strobe |
| b_oe | input | 1 | Port B read enable |
| b_side | input | 4 | Port B dedicated address lines |
| b_bus_out | output | 8 | Port B multiplexed bus, output side |
| b_bus_oe | output | 1 | Port B bus drive enable |
| rom_addr | output | 24 | Shared ROM address / bank selects |
| rom_data | input | 8 | Shared ROM data |
| inv_in | input | 1 | Inverter input |
| inv_out | output | 1 | Inverter output |

## Verification
A bad byte tracker swaps the low and middle address bytes. That swap changes the ROM byte returned on the next read, which shows up as soon as the output-enable rises. If the arbiter or slot counter fails, one port's request stays pending. The bounded-wait counter then reports it within `3*SLOT_LEN` clocks, and the port returns stale data on its read. An error in the bank decode appears on `rom_addr[23:20]` during the access slot, either as more than one low line or as a low line while idle. It also changes the returned byte.

// File: rtl/sbr_pkg.sv
package sbr_pkg;
  localparam int BYTE_W   = 8;
  localparam int ADDR_W   = 22;
  localparam int ROM_AW   = 24;
  localparam int SEL_N    = 4;
  localparam int SEL_LSB  = ROM_AW - SEL_N;
  localparam int SEL_SRC  = 20;
  localparam int SEL_SW   = $clog2(SEL_N);

  typedef enum logic {PH_LOW = 1'b0, PH_MID = 1'b1} phase_e;
endpackage

// File: rtl/sbr_port.sv
module sbr_port
  import sbr_pkg::*;
#(
  parameter int SIDE_W   = 6,
  parameter int LOW_SIDE = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [BYTE_W-1:0] bus_in,
  input  logic              strobe,
  input  logic              oe,
  input  logic [SIDE_W-1:0] side,
  input  logic              gnt,
  input  logic              wr,
  input  logic [BYTE_W-1:0] rom_byte,
  output logic [ADDR_W-1:0] addr,
  output logic              pend,
  output logic [BYTE_W-1:0] bus_out,
  output logic              bus_oe
);
  localparam int MID_LSB  = BYTE_W + LOW_SIDE;
  localparam int HIGH_LSB = 2 * BYTE_W + LOW_SIDE;
  localparam logic [SIDE_W-1:0] LOW_MASK = SIDE_W'((1 << LOW_SIDE) - 1);

  logic              strobe_q, oe_q;
  logic              st_rise, oe_rise;
  phase_e            phase;
  logic [BYTE_W-1:0] low_q, mid_q, data_q;
  logic [SIDE_W-1:0] side_q;

  assign st_rise = strobe & ~strobe_q;
  assign oe_rise = oe & ~oe_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      strobe_q <= 1'b0;
      oe_q     <= 1'b0;
      phase    <= PH_LOW;
      low_q    <= '0;
      mid_q    <= '0;
      side_q   <= '0;
      pend     <= 1'b0;
      data_q   <= '0;
    end else begin
      strobe_q <= strobe;
      oe_q     <= oe;
      if (oe_rise) begin
        phase <= PH_LOW;
      end else if (st_rise) begin
        if (phase == PH_LOW) begin
          low_q <= bus_in;
          phase <= PH_MID;
        end else begin
          mid_q  <= bus_in;
          side_q <= side;
          phase  <= PH_LOW;
        end
      end
      if (st_rise && !oe_rise && phase == PH_MID) begin
        pend <= 1'b1;
      end else if (gnt) begin
        pend <= 1'b0;
      end
      if (wr) begin
        data_q <= rom_byte;
      end
    end
  end

  assign addr = ADDR_W'(low_q)
              | (ADDR_W'(side_q & LOW_MASK) << BYTE_W)
              | (ADDR_W'(mid_q) << MID_LSB)
              | (ADDR_W'(side_q >> LOW_SIDE) << HIGH_LSB);

  assign bus_oe  = oe;
  assign bus_out = oe ? data_q : '0;
endmodule

// File: rtl/sbr_slot_arb.sv
module sbr_slot_arb
  import sbr_pkg::*;
#(
  parameter int SLOT_LEN = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pend_a,
  input  logic              pend_b,
  input  logic [ADDR_W-1:0] addr_a,
  input  logic [ADDR_W-1:0] addr_b,
  output logic              gnt_a,
  output logic              gnt_b,
  output logic              wr_a,
  output logic              wr_b,
  output logic              busy,
  output logic [ADDR_W-1:0] addr_q,
  output logic [$clog2(SLOT_LEN)-1:0] cnt
);
  localparam int CNT_W = $clog2(SLOT_LEN);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(SLOT_LEN - 1);

  logic start, pick_b, done, cur_b, last_b;

  assign start  = (cnt == '0) && !busy && (pend_a || pend_b);
  assign pick_b = pend_b && (!pend_a || !last_b);
  assign done   = busy && (cnt == LAST);
  assign gnt_a  = start && !pick_b;
  assign gnt_b  = start && pick_b;
  assign wr_a   = done && !cur_b;
  assign wr_b   = done && cur_b;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      busy   <= 1'b0;
      cur_b  <= 1'b0;
      last_b <= 1'b1;
      addr_q <= '0;
    end else begin
      cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
      if (start) begin
        busy   <= 1'b1;
        cur_b  <= pick_b;
        addr_q <= pick_b ? addr_b : addr_a;
      end else if (done) begin
        busy   <= 1'b0;
        last_b <= cur_b;
      end
    end
  end
endmodule

// File: rtl/sbr_bank_map.sv
module sbr_bank_map
  import sbr_pkg::*;
(
  input  logic              linear_mode,
  input  logic              busy,
  input  logic [ADDR_W-1:0] addr_q,
  output logic [ROM_AW-1:0] rom_addr
);
  logic [SEL_N-1:0]  sel_n;
  logic [SEL_SW-1:0] bank;

  assign bank = addr_q[SEL_SRC +: SEL_SW];

  for (genvar i = 0; i < SEL_N; i++) begin : g_sel
    assign sel_n[i] = !(busy && (bank == SEL_SW'(i)));
  end

  always_comb begin
    rom_addr = ROM_AW'(addr_q);
    if (!linear_mode) begin
      rom_addr[ROM_AW-1:SEL_LSB] = sel_n;
    end
  end
endmodule

// File: rtl/sample_rom_bridge.sv
module sample_rom_bridge
  import sbr_pkg::*;
#(
  parameter int SLOT_LEN = 4
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        linear_mode,
  input  logic [7:0]  a_bus_in,
  input  logic        a_strobe,
  input  logic        a_oe,
  input  logic [5:0]  a_side,
  output logic [7:0]  a_bus_out,
  output logic        a_bus_oe,
  input  logic [7:0]  b_bus_in,
  input  logic        b_strobe,
  input  logic        b_oe,
  input  logic [3:0]  b_side,
  output logic [7:0]  b_bus_out,
  output logic        b_bus_oe,
  output logic [23:0] rom_addr,
  input  logic [7:0]  rom_data,
  input  logic        inv_in,
  output logic        inv_out
);
  localparam int CNT_W = $clog2(SLOT_LEN);

  logic [ADDR_W-1:0] a_addr, b_addr, acc_addr;
  logic              a_pend, b_pend, a_gnt, b_gnt, a_wr, b_wr, acc_busy;
  logic [CNT_W-1:0]  slot_cnt;

  sbr_port #(.SIDE_W(6), .LOW_SIDE(2)) u_port_a (
    .clk(clk), .rst(rst), .bus_in(a_bus_in), .strobe(a_strobe), .oe(a_oe),
    .side(a_side), .gnt(a_gnt), .wr(a_wr), .rom_byte(rom_data),
    .addr(a_addr), .pend(a_pend), .bus_out(a_bus_out), .bus_oe(a_bus_oe)
  );

  sbr_port #(.SIDE_W(4), .LOW_SIDE(4)) u_port_b (
    .clk(clk), .rst(rst), .bus_in(b_bus_in), .strobe(b_strobe), .oe(b_oe),
    .side(b_side), .gnt(b_gnt), .wr(b_wr), .rom_byte(rom_data),
    .addr(b_addr), .pend(b_pend), .bus_out(b_bus_out), .bus_oe(b_bus_oe)
  );

  sbr_slot_arb #(.SLOT_LEN(SLOT_LEN)) u_arb (
    .clk(clk), .rst(rst), .pend_a(a_pend), .pend_b(b_pend),
    .addr_a(a_addr), .addr_b(b_addr), .gnt_a(a_gnt), .gnt_b(b_gnt),
    .wr_a(a_wr), .wr_b(b_wr), .busy(acc_busy), .addr_q(acc_addr),
    .cnt(slot_cnt)
  );

  sbr_bank_map u_map (
    .linear_mode(linear_mode), .busy(acc_busy), .addr_q(acc_addr),
    .rom_addr(rom_addr)
  );

  assign inv_out = ~inv_in;
endmodule

// File: rtl/sbr_checker.sv
module sbr_checker #(
  parameter int SLOT_LEN = 4
) (
  input logic        clk,
  input logic        rst,
  input logic        linear_mode,
  input logic        acc_busy,
  input logic        a_pend,
  input logic        b_pend,
  input logic [23:0] rom_addr,
  input logic        a_oe,
  input logic        a_bus_oe,
  input logic        inv_in,
  input logic        inv_out
);
  localparam int LIMIT = 3 * SLOT_LEN;
  localparam int WAIT_W = $clog2(LIMIT + 2);

  logic [WAIT_W-1:0] a_wait, b_wait;

  always_ff @(posedge clk) begin
    if (rst) begin
      a_wait <= '0;
      b_wait <= '0;
    end else begin
      a_wait <= a_pend ? a_wait + 1'b1 : '0;
      b_wait <= b_pend ? b_wait + 1'b1 : '0;
    end
  end

  p_wait_a_r6: assert property (@(posedge clk) disable iff (rst)
    a_wait < WAIT_W'(LIMIT));
  p_wait_b_r6: assert property (@(posedge clk) disable iff (rst)
    b_wait < WAIT_W'(LIMIT));
  p_sel_onehot_r7: assert property (@(posedge clk) disable iff (rst)
    (!linear_mode && acc_busy) |-> $countones(~rom_addr[23:20]) == 1);
  p_sel_idle_r8: assert property (@(posedge clk) disable iff (rst)
    (!linear_mode && !acc_busy) |-> rom_addr[23:20] == 4'hF);
  p_addr_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (acc_busy && $past(acc_busy) && $stable(linear_mode)) |-> $stable(rom_addr));
  p_release_r5: assert property (@(posedge clk) disable iff (rst)
    !a_oe |-> !a_bus_oe);
  always_comb begin
    if (!rst) begin
      p_inv_r9: assert (inv_out != inv_in);
    end
  end
endmodule

bind sample_rom_bridge sbr_checker #(.SLOT_LEN(SLOT_LEN)) u_chk (
  .clk(clk), .rst(rst), .linear_mode(linear_mode), .acc_busy(acc_busy),
  .a_pend(a_pend), .b_pend(b_pend), .rom_addr(rom_addr), .a_oe(a_oe),
  .a_bus_oe(a_bus_oe), .inv_in(inv_in), .inv_out(inv_out)
);

// File: tb/sim_sample_rom_bridge.sv
module sim_sample_rom_bridge;
  localparam int CLK_PERIOD = 10;
  localparam int SLOT_LEN   = 4;
  localparam int WAIT_CYC   = 3 * SLOT_LEN + 3;

  logic        clk = 1'b0, rst = 1'b1, linear_mode = 1'b1;
  logic [7:0]  a_bus_in = '0, b_bus_in = '0;
  logic        a_strobe = 1'b0, a_oe = 1'b0, b_strobe = 1'b0, b_oe = 1'b0;
  logic [5:0]  a_side = '0;
  logic [3:0]  b_side = '0;
  logic [7:0]  a_bus_out, b_bus_out, rom_data;
  logic        a_bus_oe, b_bus_oe, inv_in = 1'b0, inv_out;
  logic [23:0] rom_addr;

  int n_checks = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign rom_data = rom_addr[7:0] ^ rom_addr[15:8] ^ rom_addr[23:16];

  sample_rom_bridge #(.SLOT_LEN(SLOT_LEN)) u0 (
    .clk(clk), .rst(rst), .linear_mode(linear_mode),
    .a_bus_in(a_bus_in), .a_strobe(a_strobe), .a_oe(a_oe), .a_side(a_side),
    .a_bus_out(a_bus_out), .a_bus_oe(a_bus_oe),
    .b_bus_in(b_bus_in), .b_strobe(b_strobe), .b_oe(b_oe), .b_side(b_side),
    .b_bus_out(b_bus_out), .b_bus_oe(b_bus_oe),
    .rom_addr(rom_addr), .rom_data(rom_data), .inv_in(inv_in), .inv_out(inv_out)
  );

  // vector: {port_b, linear, low[7:0], mid[7:0], side[5:0]}
  localparam logic [23:0] VEC [0:5] = '{
    {1'b0, 1'b1, 8'h12, 8'h34, 6'h2D},
    {1'b1, 1'b1, 8'hA5, 8'h5A, 6'h09},
    {1'b0, 1'b0, 8'hFF, 8'h01, 6'h3E},
    {1'b1, 1'b0, 8'h3C, 8'hC3, 6'h0F},
    {1'b0, 1'b0, 8'h00, 8'h80, 6'h17},
    {1'b0, 1'b1, 8'h77, 8'hE1, 6'h20}
  };

  function automatic logic [21:0] exp_addr(bit pb, logic [7:0] lo, logic [7:0] mi,
                                           logic [5:0] sd);
    if (pb) return {2'b00, mi, sd[3:0], lo};
    return {sd[5:2], mi, sd[1:0], lo};
  endfunction

  function automatic logic [7:0] exp_byte(bit lin, logic [21:0] ad);
    logic [23:0] r;
    r = {2'b00, ad};
    if (!lin) r[23:20] = ~(4'b0001 << ad[21:20]);
    return r[7:0] ^ r[15:8] ^ r[23:16];
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] expv);
    n_checks++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic step(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic strobe_byte(bit pb, logic [7:0] v);
    @(negedge clk);
    if (pb) begin b_bus_in = v; b_strobe = 1'b1; end
    else    begin a_bus_in = v; a_strobe = 1'b1; end
    @(negedge clk);
    b_strobe = 1'b0; a_strobe = 1'b0;
  endtask

  task automatic request(bit pb, logic [7:0] lo, logic [7:0] mi, logic [5:0] sd);
    if (pb) b_side = sd[3:0]; else a_side = sd;
    strobe_byte(pb, lo);
    strobe_byte(pb, mi);
  endtask

  task automatic read_check(string req, bit pb, logic [7:0] expv);
    @(negedge clk);
    if (pb) b_oe = 1'b1; else a_oe = 1'b1;
    #1;
    check(req, pb ? {31'b0, b_bus_oe} : {31'b0, a_bus_oe}, 32'd1);
    check(req, pb ? {24'b0, b_bus_out} : {24'b0, a_bus_out}, {24'b0, expv});
    @(negedge clk);
    b_oe = 1'b0; a_oe = 1'b0;
    #1;
    check("R5", pb ? {31'b0, b_bus_oe} : {31'b0, a_bus_oe}, 32'd0);
    check("R5", pb ? {24'b0, b_bus_out} : {24'b0, a_bus_out}, 32'd0);
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    n_checks++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    linear_mode = 1'b0;
    step(3);
    rst = 1'b0;
    #1;
    check("R1", {28'b0, rom_addr[23:20]}, 32'hF);
    check("R1", {30'b0, a_bus_oe, b_bus_oe}, 32'd0);
    check("R1", {16'b0, a_bus_out, b_bus_out}, 32'd0);

    inv_in = 1'b0; #1; check("R9", {31'b0, inv_out}, 32'd1);
    inv_in = 1'b1; #1; check("R9", {31'b0, inv_out}, 32'd0);

    for (int i = 0; i < 6; i++) begin
      logic [23:0] v;
      logic [21:0] ad;
      v = VEC[i];
      linear_mode = v[22];
      ad = exp_addr(v[23], v[21:14], v[13:6], v[5:0]);
      request(v[23], v[21:14], v[13:6], v[5:0]);
      step(WAIT_CYC);
      read_check(v[23] ? (v[22] ? "R3" : "R7") : (v[22] ? "R2" : "R7"),
                 v[23], exp_byte(v[22], ad));
      if (!v[22]) begin
        #1;
        check("R8", {28'b0, rom_addr[23:20]}, 32'hF);
      end
    end

    // R6: both ports at once
    linear_mode = 1'b1;
    a_side = 6'h15; b_side = 4'hA;
    @(negedge clk);
    a_bus_in = 8'h11; b_bus_in = 8'h22; a_strobe = 1'b1; b_strobe = 1'b1;
    @(negedge clk);
    a_strobe = 1'b0; b_strobe = 1'b0;
    @(negedge clk);
    a_bus_in = 8'h33; b_bus_in = 8'h44; a_strobe = 1'b1; b_strobe = 1'b1;
    @(negedge clk);
    a_strobe = 1'b0; b_strobe = 1'b0;
    step(WAIT_CYC);
    read_check("R6", 1'b0, exp_byte(1'b1, exp_addr(1'b0, 8'h11, 8'h33, 6'h15)));
    read_check("R6", 1'b1, exp_byte(1'b1, exp_addr(1'b1, 8'h22, 8'h44, 6'h0A)));

    // R6: B first, then A issued during B's slot window
    request(1'b1, 8'h9E, 8'h6B, 6'h03);
    request(1'b0, 8'h4F, 8'hD2, 6'h2A);
    step(WAIT_CYC);
    read_check("R6", 1'b1, exp_byte(1'b1, exp_addr(1'b1, 8'h9E, 8'h6B, 6'h03)));
    read_check("R6", 1'b0, exp_byte(1'b1, exp_addr(1'b0, 8'h4F, 8'hD2, 6'h2A)));

    // R4: a stray single strobe, then an output-enable, then a full request
    strobe_byte(1'b0, 8'hEE);
    @(negedge clk); a_oe = 1'b1;
    @(negedge clk); a_oe = 1'b0;
    request(1'b0, 8'h5C, 8'h19, 6'h00);
    step(WAIT_CYC);
    read_check("R4", 1'b0, exp_byte(1'b1, exp_addr(1'b0, 8'h5C, 8'h19, 6'h00)));

    // R8 after reset re-entry
    linear_mode = 1'b0;
    rst = 1'b1; step(2); rst = 1'b0; #1;
    check("R8", {28'b0, rom_addr[23:20]}, 32'hF);
    check("R1", {30'b0, a_bus_oe, b_bus_oe}, 32'd0);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule